// File: doc/BRIEF.md
# Preloadable Event Counter Bank

This block is a set of hardware event counters that watches a memory controller. Counter 0 advances on every clock and serves as the time base. The remaining counters each advance on one event input, and software picks that input with a code. One of these general counters has a companion byte counter. The byte counter adds a per-event byte count and is governed by the same control register as its host.

Software arms a counter in two writes. The first write is all zeros. The second write carries enable, a clear strobe, the event code and an 8-bit preload value. The clear strobe loads the counter with the preload value in its top eight bits and zeros below. Preloading the cycle counter near its top value makes it wrap, and so interrupt, far sooner than a full-range count would. Software can then harvest the other counters on each interrupt, before a byte counter has a chance to wrap.

When the byte counter wraps, it freezes itself and its host counter until the next clear. The cycle counter's overflow flag drives the interrupt line directly, and the line stays high until software writes the flag back to zero.

Top module: `perf_cnt_bank`

## Requirements
- R1: After reset, every control register, every counter and the byte counter read 0, and `irq` is low.
- R2: A control write with bit 1 (clear) set loads the counter with {bits 23:16 of the write, zeros} on that clock. A write without bit 1 leaves the counter value alone.
- R3: A control register reads back with the overflow flag in bit 0, 0 in bit 1, enable in bit 2, the preload field in bits 23:16 and the event code in bits 31:24. All other bits read 0.
- R4: While enabled, counter 0 advances by one on every clock.
- R5: While enabled, a general counter advances by one on each clock in which the event input bit indexed by its event code is high. It ignores the other bits. A code that is not below the number of event inputs counts nothing.
- R6: A counter whose enable bit is 0 holds its value.
- R7: A counter that advances from all ones wraps to 0 and sets its overflow flag. A general counter keeps counting after it wraps.
- R8: `irq` equals counter 0's overflow flag. The flags of the other counters do not drive it.
- R9: An overflow flag stays set until a write to its control register with bit 0 at 0. A write with bit 0 at 1 leaves the flag unchanged.
- R10: The byte counter (value at address 13) shares counter 1's control register. It loads the same preload on clear and adds `byteIn` on each clock in which counter 1 advances.
- R11: When the byte counter wraps past all ones, counter 1's overflow flag is set and both counter 1 and the byte counter stop. They stay stopped until a clear write to control register 1.
- R12: Counter values read at addresses 8 to 12 (counters 0 to 4) and 13 (byte counter) and cannot be written. A write to those addresses changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Write address (0 to 4 are the control registers) |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Read address |
| rdData | output | 32 | Read data for rdAddr, combinational |
| evtIn | input | NUM_EVT | Event pulses, one bit per event code |
| byteIn | input | 8 | Bytes moved by the current event |
| irq | output | 1 | Cycle counter overflow interrupt |

## Verification
The bench drives the cycle counter from a preload of 0xF0 and watches the wrap. A design that preloaded the wrong bits, or missed the carry out of all ones, would raise the interrupt one cycle late, early, or never. The interrupt is then written with its flag bit held at 1 and afterwards at 0. A design that cleared the flag on any write, or on none, would drop the line at the wrong write. The byte counter is pushed across its wrap while the host keeps seeing events. A design that failed to freeze both counters, or froze the wrong one, or raised the interrupt from this flag, would show drifting counts. An out-of-range event code, a disabled counter and a write to a counter address all check that nothing moves.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
  localparam int CP_W    = 8;
  localparam int EVT_W   = 8;
  localparam int REG_W   = 32;
  localparam int OVF_BIT = 0;
  localparam int CLR_BIT = 1;
  localparam int EN_BIT  = 2;
  localparam int CP_LSB  = 16;
  localparam int EVT_LSB = 24;

  // strobes from control to datapath, one per counter
  typedef struct packed {
    logic            load;
    logic            inc;
    logic [CP_W-1:0] cp;
  } cntStb_t;

  typedef struct packed {
    logic             en;
    logic             ovf;
    logic             halt;
    logic [CP_W-1:0]  cp;
    logic [EVT_W-1:0] evt;
  } ctrlState_t;
endpackage

// File: rtl/pcb_ctrl.sv
`timescale 1ns/1ps
module pcb_ctrl
  import pcb_pkg::*;
#(
  parameter int NUM_CNT  = 5,
  parameter int NUM_EVT  = 8,
  parameter int HOST_IDX = 1,
  parameter int ADDR_W   = 4
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               wrAddr,
  input  logic [REG_W-1:0]                wrData,
  input  logic [NUM_EVT-1:0]              evtIn,
  input  logic [NUM_CNT-1:0]              wrapVec,
  input  logic                            byteWrap,
  output cntStb_t [NUM_CNT-1:0]           stb,
  output logic [NUM_CNT-1:0][REG_W-1:0]   ctrlRd,
  output logic                            irq
);
  logic [NUM_CNT-1:0] ovfVec;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_reg
    ctrlState_t cfg;
    logic hit, evHit, hostWrap;

    assign hit      = wrEn && (wrAddr == ADDR_W'(i));
    assign hostWrap = (i == HOST_IDX) && byteWrap;

    if (i == 0) begin : g_cyc
      assign evHit = 1'b1;
    end else begin : g_evt
      always_comb begin
        evHit = 1'b0;
        for (int e = 0; e < NUM_EVT; e++)
          if (cfg.evt == EVT_W'(e)) evHit = evtIn[e];
      end
    end

    assign stb[i].inc  = cfg.en && !cfg.halt && evHit;
    assign stb[i].load = hit && wrData[CLR_BIT];
    assign stb[i].cp   = wrData[CP_LSB +: CP_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfg <= '0;
      end else if (hit) begin
        cfg.en   <= wrData[EN_BIT];
        cfg.cp   <= wrData[CP_LSB +: CP_W];
        cfg.evt  <= wrData[EVT_LSB +: EVT_W];
        cfg.ovf  <= (cfg.ovf && wrData[OVF_BIT]) || wrapVec[i] || hostWrap;
        cfg.halt <= wrData[CLR_BIT] ? 1'b0 : (cfg.halt || hostWrap);
      end else begin
        cfg.ovf  <= cfg.ovf || wrapVec[i] || hostWrap;
        cfg.halt <= cfg.halt || hostWrap;
      end
    end

    assign ctrlRd[i] = {cfg.evt, cfg.cp, 13'b0, cfg.en, 1'b0, cfg.ovf};
    assign ovfVec[i] = cfg.ovf;
  end

  assign irq = ovfVec[0];
endmodule

// File: rtl/pcb_dpath.sv
`timescale 1ns/1ps
module pcb_dpath
  import pcb_pkg::*;
#(
  parameter int NUM_CNT  = 5,
  parameter int CNT_W    = 32,
  parameter int BYTE_W   = 8,
  parameter int HOST_IDX = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  cntStb_t [NUM_CNT-1:0]         stb,
  input  logic [BYTE_W-1:0]             byteIn,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0]              byteVal,
  output logic [NUM_CNT-1:0]            wrapVec,
  output logic                          byteWrap
);
  localparam int LOW_W = CNT_W - CP_W;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign wrapVec[i] = stb[i].inc && !stb[i].load && (&cntVal[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cntVal[i] <= '0;
      else if (stb[i].load)  cntVal[i] <= {stb[i].cp, {LOW_W{1'b0}}};
      else if (stb[i].inc)   cntVal[i] <= cntVal[i] + 1'b1;
    end
  end

  logic [CNT_W:0] byteSum;
  assign byteSum  = {1'b0, byteVal} + (CNT_W+1)'(byteIn);
  assign byteWrap = stb[HOST_IDX].inc && !stb[HOST_IDX].load && byteSum[CNT_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     byteVal <= '0;
    else if (stb[HOST_IDX].load)   byteVal <= {stb[HOST_IDX].cp, {LOW_W{1'b0}}};
    else if (stb[HOST_IDX].inc)    byteVal <= byteSum[CNT_W-1:0];
  end
endmodule

// File: rtl/perf_cnt_bank.sv
`timescale 1ns/1ps
module perf_cnt_bank
  import pcb_pkg::*;
#(
  parameter int NUM_GEN  = 4,
  parameter int CNT_W    = 32,
  parameter int NUM_EVT  = 8,
  parameter int BYTE_W   = 8,
  parameter int HOST_IDX = 1,
  parameter int ADDR_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [31:0]        wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [31:0]        rdData,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [BYTE_W-1:0]  byteIn,
  output logic               irq
);
  localparam int NUM_CNT  = NUM_GEN + 1;
  localparam int CNT_BASE = 8;
  localparam int BYTE_ADR = CNT_BASE + NUM_CNT;

  cntStb_t [NUM_CNT-1:0]         stb;
  logic [NUM_CNT-1:0][REG_W-1:0] ctrlRd;
  logic [NUM_CNT-1:0][CNT_W-1:0] cntVal;
  logic [CNT_W-1:0]              byteVal;
  logic [NUM_CNT-1:0]            wrapVec;
  logic                          byteWrap;

  pcb_ctrl #(.NUM_CNT(NUM_CNT), .NUM_EVT(NUM_EVT), .HOST_IDX(HOST_IDX), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .evtIn(evtIn), .wrapVec(wrapVec), .byteWrap(byteWrap),
    .stb(stb), .ctrlRd(ctrlRd), .irq(irq)
  );

  pcb_dpath #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .BYTE_W(BYTE_W), .HOST_IDX(HOST_IDX)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIn(byteIn),
    .cntVal(cntVal), .byteVal(byteVal), .wrapVec(wrapVec), .byteWrap(byteWrap)
  );

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (rdAddr == ADDR_W'(i))            rdData = ctrlRd[i];
      if (rdAddr == ADDR_W'(CNT_BASE + i)) rdData = 32'(cntVal[i]);
    end
    if (rdAddr == ADDR_W'(BYTE_ADR))       rdData = 32'(byteVal);
  end
endmodule

// File: rtl/pcb_chk.sv
`timescale 1ns/1ps
module pcb_chk #(
  parameter int NUM_CNT  = 5,
  parameter int CNT_W    = 32,
  parameter int HOST_IDX = 1,
  parameter int ADDR_W   = 4
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          wrEn,
  input logic [ADDR_W-1:0]             wrAddr,
  input logic [31:0]                   wrData,
  input logic                          irq,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cntVal,
  input logic                          byteWrap
);
  p_preload_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_W'(0) && wrData[1]) |=>
      cntVal[0] == {$past(wrData[23:16]), {(CNT_W-8){1'b0}}});

  p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn && wrAddr == ADDR_W'(1) && !wrData[2] && !wrData[1]) &&
     !(wrEn && wrAddr == ADDR_W'(1))) |=> $stable(cntVal[1]));

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(cntVal[0]) == {CNT_W{1'b1}}));

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(wrEn && wrAddr == ADDR_W'(0) && !wrData[0]));

  p_byte_halt_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(byteWrap) && !(wrEn && wrAddr == ADDR_W'(HOST_IDX) && wrData[1]))
      |=> $stable(cntVal[HOST_IDX]));
endmodule

bind perf_cnt_bank pcb_chk #(
  .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .HOST_IDX(HOST_IDX), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .irq(irq), .cntVal(cntVal), .byteWrap(byteWrap)
);

// File: tb/perf_cnt_bank_tb.sv
`timescale 1ns/1ps
module perf_cnt_bank_tb;
  localparam int CW   = 16;
  localparam int NEVT = 4;
  localparam int NCNT = 5;
  localparam int HOST = 1;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [3:0] wrAddr = '0, rdAddr = '0;
  logic [31:0] wrData = '0, rdData;
  logic [NEVT-1:0] evtIn = '0;
  logic [7:0] byteIn = '0;
  logic irq;

  always #2.5 clk = ~clk;

  perf_cnt_bank #(.NUM_GEN(4), .CNT_W(CW), .NUM_EVT(NEVT), .BYTE_W(8), .HOST_IDX(HOST), .ADDR_W(4)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .evtIn(evtIn), .byteIn(byteIn), .irq(irq)
  );

  int nRun = 0, nFail = 0;
  string curReq = "R1";
  bit finished = 1'b0;

  // behavioural reference state
  int  mCnt[NCNT], mCp[NCNT], mEvt[NCNT];
  bit  mEn[NCNT], mOvf[NCNT], mHalt[NCNT];
  int  mByte;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(logic [3:0] a);
    if (a < NCNT)
      return {mEvt[a][7:0], mCp[a][7:0], 13'b0, mEn[a], 1'b0, mOvf[a]};
    if (a >= 8 && a < 8 + NCNT) return 32'(mCnt[a-8]);
    if (a == 8 + NCNT) return 32'(mByte);
    return 32'h0;
  endfunction

  task automatic modelStep();
    bit inc[NCNT], ld[NCNT], wrap[NCNT], hit[NCNT];
    bit bwrap;
    int bsum;
    if (!rstN) begin
      for (int i = 0; i < NCNT; i++) begin
        mCnt[i] = 0; mCp[i] = 0; mEvt[i] = 0; mEn[i] = 0; mOvf[i] = 0; mHalt[i] = 0;
      end
      mByte = 0;
      return;
    end
    for (int i = 0; i < NCNT; i++) begin
      bit evOk;
      hit[i] = wrEn && (wrAddr == 4'(i));
      ld[i]  = hit[i] && wrData[1];
      evOk   = (i == 0) || (mEvt[i] < NEVT && evtIn[mEvt[i]]);
      inc[i] = mEn[i] && !mHalt[i] && evOk;
      wrap[i] = inc[i] && !ld[i] && (mCnt[i] == MAXV);
    end
    bsum  = mByte + int'(byteIn);
    bwrap = inc[HOST] && !ld[HOST] && (bsum > MAXV);
    if (ld[HOST])       mByte = int'(wrData[23:16]) << (CW - 8);
    else if (inc[HOST]) mByte = bsum & MAXV;
    for (int i = 0; i < NCNT; i++) begin
      bit hw;
      hw = (i == HOST) && bwrap;
      if (ld[i])       mCnt[i] = int'(wrData[23:16]) << (CW - 8);
      else if (inc[i]) mCnt[i] = (mCnt[i] + 1) & MAXV;
      if (hit[i]) begin
        mOvf[i]  = (mOvf[i] && wrData[0]) || wrap[i] || hw;
        mHalt[i] = ld[i] ? 1'b0 : (mHalt[i] || hw);
        mEn[i]   = wrData[2];
        mCp[i]   = int'(wrData[23:16]);
        mEvt[i]  = int'(wrData[31:24]);
      end else begin
        mOvf[i]  = mOvf[i] || wrap[i] || hw;
        mHalt[i] = mHalt[i] || hw;
      end
    end
  endtask

  // one clock: model follows the edge, then both are compared
  task automatic tick();
    @(posedge clk);
    modelStep();
    #2;
    if (rstN) begin
      chk(curReq, rdData, expRead(rdAddr));
      chk({curReq, " irq"}, {31'b0, irq}, {31'b0, mOvf[0]});
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  task automatic regWrite(logic [3:0] a, logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readChk(string req, logic [3:0] a, logic [31:0] exp);
    rdAddr = a;
    #0.5;
    chk(req, rdData, exp);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    ticks(4);
    rstN = 1'b1;
    tick();
    // R1: reset state
    curReq = "R1";
    for (int a = 0; a < 16; a++) readChk("R1", 4'(a), 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 / R3: two-write arming of the cycle counter with preload 0xF0
    curReq = "R2";
    regWrite(4'd0, 32'h0);
    regWrite(4'd0, 32'h00F0_0006);
    readChk("R2", 4'd8, 32'h0000_F000);
    readChk("R3", 4'd0, 32'h00F0_0004);

    // R4: one count per clock
    curReq = "R4";
    rdAddr = 4'd8;
    ticks(10);
    readChk("R4", 4'd8, 32'h0000_F00A);

    // R7 / R8: wrap of the cycle counter raises irq
    curReq = "R8";
    ticks(4085);
    readChk("R7", 4'd8, 32'h0000_FFFF);
    chk("R8 irq before wrap", {31'b0, irq}, 32'h0);
    tick();
    readChk("R7", 4'd8, 32'h0);
    chk("R8 irq after wrap", {31'b0, irq}, 32'h1);

    // R9: flag write-1 keeps, write-0 clears; no reload without clear
    curReq = "R9";
    regWrite(4'd0, 32'h00F0_0005);
    chk("R9 irq kept", {31'b0, irq}, 32'h1);
    regWrite(4'd0, 32'h00F0_0004);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    readChk("R2 no reload", 4'd8, 32'h2);

    // R5: counter 2 selects event code 3
    curReq = "R5";
    regWrite(4'd2, 32'h0);
    regWrite(4'd2, 32'h0300_0006);
    rdAddr = 4'd10;
    evtIn = 4'b1000; ticks(3);
    evtIn = 4'b0111; ticks(3);
    evtIn = 4'b0000;
    readChk("R5", 4'd10, 32'h3);

    // R6: disabled counter holds
    curReq = "R6";
    regWrite(4'd2, 32'h0);
    evtIn = 4'b1000; ticks(4); evtIn = 4'b0000;
    readChk("R6", 4'd10, 32'h3);

    // R5: out-of-range code counts nothing
    curReq = "R5";
    regWrite(4'd2, 32'h2000_0006);
    evtIn = 4'b1111; ticks(5); evtIn = 4'b0000;
    readChk("R5 bad code", 4'd10, 32'h0);

    // R7 / R8: general counter wraps, sets its flag, keeps counting, no irq
    curReq = "R7";
    regWrite(4'd2, 32'h03FF_0006);
    readChk("R2 general", 4'd10, 32'h0000_FF00);
    rdAddr = 4'd10;
    evtIn = 4'b1000; ticks(256); evtIn = 4'b0000;
    readChk("R7 wrap", 4'd10, 32'h0);
    readChk("R7 flag", 4'd2, 32'h03FF_0005);
    chk("R8 no irq from counter 2", {31'b0, irq}, 32'h0);
    evtIn = 4'b1000; ticks(2); evtIn = 4'b0000;
    readChk("R7 continues", 4'd10, 32'h2);

    // R10: byte counter shares control register 1
    curReq = "R10";
    regWrite(4'd1, 32'h0);
    regWrite(4'd1, 32'h01FF_0006);
    readChk("R10 host preload", 4'd9, 32'h0000_FF00);
    readChk("R10 byte preload", 4'd13, 32'h0000_FF00);
    rdAddr = 4'd13;
    byteIn = 8'h30;
    evtIn = 4'b0001; tick();
    readChk("R10 other event", 4'd13, 32'h0000_FF00);
    evtIn = 4'b0010; ticks(5);
    readChk("R10 host", 4'd9, 32'h0000_FF05);
    readChk("R10 bytes", 4'd13, 32'h0000_FFF0);
    readChk("R11 no flag yet", 4'd1, 32'h01FF_0004);

    // R11: byte wrap stops host and byte counter
    curReq = "R11";
    tick();
    readChk("R11 host", 4'd9, 32'h0000_FF06);
    readChk("R11 byte wrap", 4'd13, 32'h0000_0020);
    readChk("R11 flag", 4'd1, 32'h01FF_0005);
    chk("R11 no irq", {31'b0, irq}, 32'h0);
    ticks(3);
    readChk("R11 host halted", 4'd9, 32'h0000_FF06);
    readChk("R11 byte halted", 4'd13, 32'h0000_0020);
    evtIn = 4'b0000;
    regWrite(4'd1, 32'h01FF_0006);
    evtIn = 4'b0010; tick(); evtIn = 4'b0000;
    readChk("R11 restart host", 4'd9, 32'h0000_FF01);
    readChk("R11 restart byte", 4'd13, 32'h0000_FF30);
    readChk("R11 flag cleared", 4'd1, 32'h01FF_0004);

    // R12: counter addresses are read-only
    curReq = "R12";
    regWrite(4'd9, 32'hFFFF_FFFF);
    regWrite(4'd13, 32'h0000_0000);
    readChk("R12 host", 4'd9, 32'h0000_FF01);
    readChk("R12 byte", 4'd13, 32'h0000_FF30);
    readChk("R12 ctrl1", 4'd1, 32'h01FF_0004);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule